// File: doc/BRIEF.md
# Serial Command Frame Receiver

This block takes command frames from a single serial line and a companion bit clock. Both are sampled by a fast, continuous system clock. The receiver waits for the line to sit low for a long run before it treats a rising level as the start of a frame. It then shifts in a 24-bit payload with the most significant bit first. After the payload it samples one parity bit and one stop bit. Each bit is taken at the falling edge of the bit clock.

A frame that passes every check is handed on as an 8-bit command identifier and a 16-bit data word, marked by a single-cycle valid pulse. The checks are odd parity, a low stop level and an identifier inside this unit's group. A frame that fails any check is dropped silently. No error leaves the block, and the held outputs keep their previous values. Whatever happens to a frame, the receiver then hunts for a fresh long run of zeros before it accepts the next start.

What each command means is not part of this block. The bit clock is assumed to be already synchronous to the system clock.

Top module: `cmd_frame_rx`

## Requirements
- R1: While reset is high and after it is released, cmd_valid is 0 and cmd_id and cmd_data are 0. Reset puts the receiver back into hunting with an empty zero count, so a one seen before MIN_ZEROS (default 25) zero bits have been sampled is not a start.
- R2: A one bit is taken as a frame start only if at least MIN_ZEROS consecutive zero bits were sampled just before it. After 24 zeros a one is ignored; after 25 or more it starts a frame.
- R3: The 24 payload bits that follow the start bit arrive most significant bit first. Payload bits 23..16 appear on cmd_id and bits 15..0 appear on cmd_data.
- R4: The bit after the payload is a parity bit. The frame is accepted only if the payload and the parity bit together hold an odd number of ones; the start bit is not counted.
- R5: The bit after the parity bit is the stop bit and must be 0. A stop bit of 1 rejects the frame.
- R6: A frame is accepted only when cmd_id[7:4] equals ID_GROUP (default 4'h8). Any other upper nibble rejects the frame.
- R7: Each accepted frame raises cmd_valid for exactly one system clock cycle. cmd_id and cmd_data change only on that cycle. A rejected frame raises no pulse and leaves both outputs unchanged.
- R8: After any frame, accepted or rejected, the zero count restarts after the stop bit. The next start needs MIN_ZEROS zeros counted from that point, so 25 zeros after the stop bit are enough and 24 are not.
- R9: The line is sampled only in the system clock cycle in which bit_clk is first seen low after being high. Changes on ser_in while bit_clk is high have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, continuous and faster than bit_clk |
| rst | input | 1 | Synchronous reset, active high |
| bit_clk | input | 1 | Serial bit clock; data is taken at its falling edge |
| ser_in | input | 1 | Serial command line |
| cmd_id | output | 8 | Identifier of the last accepted frame |
| cmd_data | output | 16 | Data field of the last accepted frame |
| cmd_valid | output | 1 | One-cycle pulse marking a newly accepted frame |

## Verification
The falling edge of bit_clk is detected at the first rising clk edge that sees bit_clk low. The stop bit is judged at that same edge. cmd_valid, cmd_id and cmd_data therefore change one clk cycle after the stop bit's falling edge is presented.

The bench drives every input on the falling edge of clk, holding each bit for four cycles. A monitor samples on the falling edge and counts the cycles in which cmd_valid is high. A pulse stretched past one cycle therefore shows up as a wrong count. Each frame is followed by two more zero bit periods before the pulse count and the held outputs are compared with values computed from the payload the bench sent.

// File: rtl/cmd_rx_pkg.sv
package cmd_rx_pkg;

    localparam int ID_W      = 8;
    localparam int DATA_W    = 16;
    localparam int PAYLOAD_W = ID_W + DATA_W;
    localparam int GROUP_W   = 4;

    localparam int                 DEF_MIN_ZEROS = 25;
    localparam logic [GROUP_W-1:0] DEF_ID_GROUP  = 4'h8;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_PAYLOAD,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [DATA_W-1:0] data;
    } cmd_word_t;

    // odd parity: payload plus parity bit carry an odd count of ones
    function automatic logic parity_is_odd(input logic [PAYLOAD_W-1:0] payload,
                                           input logic                 par_bit);
        return ^{payload, par_bit};
    endfunction

    function automatic logic id_in_group(input logic [ID_W-1:0]    id,
                                         input logic [GROUP_W-1:0] group);
        return id[ID_W-1 -: GROUP_W] == group;
    endfunction

endpackage

// File: rtl/cmd_rx_edge.sv
module cmd_rx_edge (
    input  logic clk,
    input  logic rst,
    input  logic bit_clk,
    output logic fall
);
    logic bclk_q;

    always_ff @(posedge clk) begin
        if (rst) bclk_q <= 1'b0;
        else     bclk_q <= bit_clk;
    end

    assign fall = bclk_q & ~bit_clk;
endmodule

// File: rtl/cmd_rx_hunt.sv
module cmd_rx_hunt #(
    parameter int MIN_ZEROS = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic sample,
    input  logic bit_in,
    input  logic busy,
    output logic armed
);
    localparam int CW = $clog2(MIN_ZEROS + 1);
    localparam logic [CW-1:0] RUN_MAX = CW'(MIN_ZEROS);

    logic [CW-1:0] zero_run;

    always_ff @(posedge clk) begin
        if (rst || busy) begin
            zero_run <= '0;
        end else if (sample) begin
            if (bit_in)
                zero_run <= '0;
            else if (zero_run != RUN_MAX)
                zero_run <= zero_run + 1'b1;
        end
    end

    assign armed = (zero_run == RUN_MAX);
endmodule

// File: rtl/cmd_rx_frame.sv
module cmd_rx_frame
    import cmd_rx_pkg::*;
#(
    parameter logic [GROUP_W-1:0] ID_GROUP = DEF_ID_GROUP
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sample,
    input  logic      bit_in,
    input  logic      armed,
    output logic      busy,
    output logic      word_valid,
    output cmd_word_t word
);
    localparam int CNT_W = $clog2(PAYLOAD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(PAYLOAD_W - 1);

    rx_state_e              state;
    logic [CNT_W-1:0]       bit_cnt;
    logic [PAYLOAD_W-1:0]   shreg;
    logic                   par_bit;
    logic                   frame_ok;

    assign frame_ok = ~bit_in
                    & parity_is_odd(shreg, par_bit)
                    & id_in_group(shreg[PAYLOAD_W-1 -: ID_W], ID_GROUP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_HUNT;
            bit_cnt    <= '0;
            shreg      <= '0;
            par_bit    <= 1'b0;
            word_valid <= 1'b0;
            word       <= '0;
        end else begin
            word_valid <= 1'b0;
            if (sample) begin
                case (state)
                    ST_HUNT: begin
                        if (bit_in && armed) begin
                            state   <= ST_PAYLOAD;
                            bit_cnt <= '0;
                        end
                    end
                    ST_PAYLOAD: begin
                        shreg <= {shreg[PAYLOAD_W-2:0], bit_in};
                        if (bit_cnt == LAST_BIT) state <= ST_PARITY;
                        else                     bit_cnt <= bit_cnt + 1'b1;
                    end
                    ST_PARITY: begin
                        par_bit <= bit_in;
                        state   <= ST_STOP;
                    end
                    ST_STOP: begin
                        state <= ST_HUNT;
                        if (frame_ok) begin
                            word_valid <= 1'b1;
                            word       <= cmd_word_t'(shreg);
                        end
                    end
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end

    assign busy = (state != ST_HUNT);
endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx
    import cmd_rx_pkg::*;
#(
    parameter int                 MIN_ZEROS = DEF_MIN_ZEROS,
    parameter logic [GROUP_W-1:0] ID_GROUP  = DEF_ID_GROUP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_clk,
    input  logic              ser_in,
    output logic [ID_W-1:0]   cmd_id,
    output logic [DATA_W-1:0] cmd_data,
    output logic              cmd_valid
);
    logic      sample;
    logic      armed;
    logic      busy;
    cmd_word_t word;

    cmd_rx_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .bit_clk (bit_clk),
        .fall    (sample)
    );

    cmd_rx_hunt #(.MIN_ZEROS(MIN_ZEROS)) u_hunt (
        .clk    (clk),
        .rst    (rst),
        .sample (sample),
        .bit_in (ser_in),
        .busy   (busy),
        .armed  (armed)
    );

    cmd_rx_frame #(.ID_GROUP(ID_GROUP)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .sample     (sample),
        .bit_in     (ser_in),
        .armed      (armed),
        .busy       (busy),
        .word_valid (cmd_valid),
        .word       (word)
    );

    assign cmd_id   = word.id;
    assign cmd_data = word.data;
endmodule

// File: rtl/cmd_frame_rx_chk.sv
module cmd_frame_rx_chk #(
    parameter logic [3:0] ID_GROUP = 4'h8
) (
    input logic        clk,
    input logic        rst,
    input logic        bit_clk,
    input logic        ser_in,
    input logic [7:0]  cmd_id,
    input logic [15:0] cmd_data,
    input logic        cmd_valid
);
    p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> (cmd_id == $past(cmd_id) && cmd_data == $past(cmd_data)));

    p_id_group_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_id[7:4] == ID_GROUP));

    p_on_fall_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ($past(bit_clk) == 1'b0 && $past(bit_clk, 2) == 1'b1));

    p_stop_low_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ($past(ser_in) == 1'b0));
endmodule

bind cmd_frame_rx cmd_frame_rx_chk #(.ID_GROUP(ID_GROUP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_clk   (bit_clk),
    .ser_in    (ser_in),
    .cmd_id    (cmd_id),
    .cmd_data  (cmd_data),
    .cmd_valid (cmd_valid)
);

// File: tb/cmd_frame_rx_tb.sv
`timescale 1ns/1ps
module cmd_frame_rx_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        bit_clk;
    logic        ser_in;
    logic [7:0]  cmd_id;
    logic [15:0] cmd_data;
    logic        cmd_valid;

    int total = 0;
    int bad   = 0;
    int pulses = 0;
    logic [7:0]  exp_id   = 8'h00;
    logic [15:0] exp_data = 16'h0000;

    always #2 clk = ~clk;

    cmd_frame_rx u_dut (
        .clk       (clk),
        .rst       (rst),
        .bit_clk   (bit_clk),
        .ser_in    (ser_in),
        .cmd_id    (cmd_id),
        .cmd_data  (cmd_data),
        .cmd_valid (cmd_valid)
    );

    always @(negedge clk) if (!rst && cmd_valid) pulses++;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        @(negedge clk); ser_in = glitch ? ~b : b; bit_clk = 1'b1;
        @(negedge clk); ser_in = b;
        @(negedge clk); bit_clk = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0, 1'b0);
    endtask

    task automatic run_frame(input string req, input int nz, input logic [23:0] pl,
                             input bit par_flip, input logic stopv,
                             input bit glitch, input bit acc);
        int p0;
        p0 = pulses;
        send_zeros(nz);
        send_bit(1'b1, glitch);
        for (int i = 23; i >= 0; i--) send_bit(pl[i], glitch);
        send_bit((~^pl) ^ par_flip, glitch);
        send_bit(stopv, glitch);
        send_zeros(2);
        if (acc) begin
            exp_id   = pl[23:16];
            exp_data = pl[15:0];
        end
        chk({req, " R7"}, "pulse cycles", 32'(pulses - p0), acc ? 32'd1 : 32'd0);
        chk(req, "cmd_id", 32'(cmd_id), 32'(exp_id));
        chk(req, "cmd_data", 32'(cmd_data), 32'(exp_data));
    endtask

    initial begin
        rst = 1'b1; bit_clk = 1'b0; ser_in = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1", "valid in reset", 32'(cmd_valid), 0);
        chk("R1", "id in reset", 32'(cmd_id), 0);
        chk("R1", "data in reset", 32'(cmd_data), 0);
        rst = 1'b0;
        // R1: hunting after reset, 10 zeros are not enough
        run_frame("R1", 10, 24'h81_2222, 0, 1'b0, 0, 0);

        // R2: 24 zeros after a fresh reset -> ignored, then 30 -> accepted
        rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
        run_frame("R2", 24, 24'h81_2345, 0, 1'b0, 0, 0);
        run_frame("R2", 30, 24'h81_1234, 0, 1'b0, 0, 1);

        // R3: walking-one data field, identifier tracks the position
        for (int k = 0; k < 16; k++)
            run_frame("R3", 25, {4'h8, 4'(k), 16'(16'h1 << k)}, 0, 1'b0, 0, 1);

        // R6: sweep of the identifier upper nibble
        for (int n = 0; n < 16; n++)
            run_frame("R6", 26, {4'(n), 4'h5, 16'(16'h1357 * (n + 1))}, 0, 1'b0, 0, n == 8);

        // R4: parity extremes and a flipped parity bit
        run_frame("R4", 26, 24'h8F_FFFF, 0, 1'b0, 0, 1);
        run_frame("R4", 26, 24'h80_0000, 0, 1'b0, 0, 1);
        run_frame("R4", 26, 24'h8C_F0F0, 1, 1'b0, 0, 0);

        // R5: stop bit high rejects
        run_frame("R5", 26, 24'h8D_0F0F, 0, 1'b1, 0, 0);

        // R8: zero count restarts after the stop bit (run_frame adds 2 zeros)
        run_frame("R8", 30, 24'h82_AAAA, 0, 1'b0, 0, 1);
        run_frame("R8", 23, 24'h83_5555, 0, 1'b0, 0, 1);
        run_frame("R8", 22, 24'h84_0101, 0, 1'b0, 0, 0);
        run_frame("R8", 30, 24'h85_7777, 1, 1'b0, 0, 0);
        run_frame("R8", 10, 24'h86_1111, 0, 1'b0, 0, 0);

        // R9: line changes while bit_clk is high are ignored
        run_frame("R9", 30, 24'h8A_5A5A, 0, 1'b0, 1, 1);
        run_frame("R9", 26, 24'h87_C3C3, 0, 1'b0, 1, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=expired exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule